// File: doc/BRIEF.md
# Sized Integer Divide and Remainder Unit

This block computes a quotient or a remainder from a 32-bit destination register value (the dividend) and a 32-bit source value (the divisor). It serves signed and unsigned division and remainder. A 16-bit immediate code picks whether the dividend is taken as a full word, a halfword or a byte. The pipeline pulses `start` with the operands. The unit then works out one quotient bit per clock from the magnitudes of the operands and fixes up the signs at the end. It raises a one-cycle `done` together with the result, and raises `wr_en` when the result is to be written back.

In the signed halfword and byte forms, only the dividend is narrowed: its low 16 or 8 bits are sign-extended to 32 bits. The divisor always stays a full word. The unsigned narrow forms take the whole 32-bit dividend as it is. When the divisor is zero, the operation still completes, but the write is withheld, so the destination keeps its old value.

Top module: `sized_divider`

## Requirements
- R1: `op_sel` selects the operation: 0 = signed quotient, 1 = unsigned quotient, 2 = signed remainder, 3 = unsigned remainder.
- R2: `size_imm` = 0x0010 selects halfword size and 0x0018 selects byte size. 0x0000, and every other value, selects word size.
- R3: In signed operations at halfword size, the dividend is bits [15:0] of `dividend`, sign-extended to 32 bits.
- R4: In signed operations at byte size, the dividend is bits [7:0] of `dividend`, sign-extended to 32 bits.
- R5: In unsigned operations at halfword or byte size, the full 32-bit `dividend` is used, with no truncation.
- R6: A signed quotient truncates toward zero. A signed remainder is zero or carries the sign of the (extended) dividend.
- R7: Signed 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0, with no other effect.
- R8: With a zero divisor, `done` still pulses, but `wr_en` stays low and `result` equals the unmodified `dividend` value captured at start. `wr_en` is never high without `done`.
- R9: A start accepted at clock edge E raises `busy` from the next cycle. `done` is high for exactly one cycle: the cycle that follows the 32nd edge after E. `busy` stays high through that cycle and falls after it.
- R10: A `start` pulse while `busy` is high is ignored. The running operation completes with its original operands, and no extra `done` follows.
- R11: While reset is asserted, and after it is released before any start, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op_sel | input | 2 | Operation code (R1) |
| size_imm | input | 16 | Size code from the immediate field (R2) |
| dividend | input | 32 | Destination register value |
| divisor | input | 32 | Source register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| wr_en | output | 1 | Write the result back to the destination |
| result | output | 32 | Quotient, remainder, or unchanged dividend |

## Verification
Small positive operands are run under all four operation codes, so that each code is shown to select the right function. The same magnitudes with every sign combination then show truncation toward zero and the sign taken by the remainder. Dividends whose upper bits disagree with the sign of their low byte or halfword are tried at every size code under both signed and unsigned operations. These separate sign-extension of the low part from use of the full word, and an unlisted immediate code shows the fallback to word size. Further cases cover the most negative value divided by minus one, zero divisors, an all-ones unsigned dividend and a start pulse issued mid-operation; these show the overflow rule, write suppression and the fixed latency.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned BYTE_W = 8;

    localparam logic [15:0] IMM_HALF = 16'h0010;
    localparam logic [15:0] IMM_BYTE = 16'h0018;

    typedef enum logic [1:0] {
        OP_SQUO = 2'd0,
        OP_UQUO = 2'd1,
        OP_SREM = 2'd2,
        OP_UREM = 2'd3
    } sdr_op_e;

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_HALF = 2'd1,
        SZ_BYTE = 2'd2
    } sdr_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sdr_state_e;

    typedef struct packed {
        logic want_rem;
        logic neg_quo;
        logic neg_rem;
        logic zero_div;
    } sdr_ctl_t;

    function automatic sdr_size_e decode_size(input logic [15:0] imm);
        if (imm == IMM_HALF)      return SZ_HALF;
        else if (imm == IMM_BYTE) return SZ_BYTE;
        else                      return SZ_WORD;
    endfunction

    function automatic logic op_is_signed(input sdr_op_e op);
        return (op == OP_SQUO) || (op == OP_SREM);
    endfunction

    function automatic logic op_is_rem(input sdr_op_e op);
        return (op == OP_SREM) || (op == OP_UREM);
    endfunction

endpackage

// File: rtl/sdr_operand_prep.sv
module sdr_operand_prep
    import sdr_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned HW = HALF_W,
    parameter int unsigned BW = BYTE_W
) (
    input  sdr_op_e        op,
    input  sdr_size_e      size,
    input  logic [W-1:0]   dividend,
    input  logic [W-1:0]   divisor,
    output logic [W-1:0]   mag_a,
    output logic [W-1:0]   mag_b,
    output sdr_ctl_t       ctl
);
    logic          is_signed;
    logic [W-1:0]  a_ext;
    logic          a_neg;
    logic          b_neg;

    assign is_signed = op_is_signed(op);

    // Narrow forms reshape only the dividend, and only when signed.
    always_comb begin
        a_ext = dividend;
        if (is_signed) begin
            unique case (size)
                SZ_HALF: a_ext = {{(W-HW){dividend[HW-1]}}, dividend[HW-1:0]};
                SZ_BYTE: a_ext = {{(W-BW){dividend[BW-1]}}, dividend[BW-1:0]};
                default: a_ext = dividend;
            endcase
        end
    end

    assign a_neg = is_signed & a_ext[W-1];
    assign b_neg = is_signed & divisor[W-1];
    assign mag_a = a_neg ? (~a_ext + 1'b1) : a_ext;
    assign mag_b = b_neg ? (~divisor + 1'b1) : divisor;

    always_comb begin
        ctl.want_rem = op_is_rem(op);
        ctl.neg_quo  = a_neg ^ b_neg;
        ctl.neg_rem  = a_neg;
        ctl.zero_div = (divisor == '0);
    end

endmodule

// File: rtl/sdr_shift_core.sv
module sdr_shift_core #(
    parameter int unsigned W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [W-1:0]  mag_a,
    input  logic [W-1:0]  mag_b,
    output logic [W-1:0]  quo,
    output logic [W-1:0]  rem
);
    logic [W-1:0] q_r;
    logic [W-1:0] r_r;
    logic [W-1:0] b_r;
    logic [W:0]   trial;
    logic [W:0]   diff;

    assign trial = {r_r, q_r[W-1]};
    assign diff  = trial - {1'b0, b_r};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
            r_r <= '0;
            b_r <= '0;
        end else if (load) begin
            q_r <= mag_a;
            r_r <= '0;
            b_r <= mag_b;
        end else if (step) begin
            if (!diff[W]) begin
                r_r <= diff[W-1:0];
                q_r <= {q_r[W-2:0], 1'b1};
            end else begin
                r_r <= trial[W-1:0];
                q_r <= {q_r[W-2:0], 1'b0};
            end
        end
    end

    assign quo = q_r;
    assign rem = r_r;

    // Partial remainder never reaches the divisor during the iteration.
    assert_partial_rem_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (b_r != '0) |-> (r_r < b_r));

endmodule

// File: rtl/sdr_result_fix.sv
module sdr_result_fix
    import sdr_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0]  quo,
    input  logic [W-1:0]  rem,
    input  logic [W-1:0]  orig,
    input  sdr_ctl_t      ctl,
    output logic [W-1:0]  result
);
    logic [W-1:0] quo_s;
    logic [W-1:0] rem_s;

    assign quo_s = ctl.neg_quo ? (~quo + 1'b1) : quo;
    assign rem_s = ctl.neg_rem ? (~rem + 1'b1) : rem;

    always_comb begin
        if (ctl.zero_div)      result = orig;
        else if (ctl.want_rem) result = rem_s;
        else                   result = quo_s;
    end

endmodule

// File: rtl/sized_divider.sv
module sized_divider
    import sdr_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    op_sel,
    input  logic [15:0]   size_imm,
    input  logic [W-1:0]  dividend,
    input  logic [W-1:0]  divisor,
    output logic          busy,
    output logic          done,
    output logic          wr_en,
    output logic [W-1:0]  result
);
    localparam int unsigned CW = $clog2(W);
    localparam int unsigned LW = $clog2(W + 2);

    sdr_state_e    state;
    logic [CW-1:0] cnt;
    logic          accept;
    logic          step;
    sdr_ctl_t      ctl_now;
    sdr_ctl_t      ctl_q;
    logic [W-1:0]  orig_q;
    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic [W-1:0]  quo;
    logic [W-1:0]  rem;

    assign accept = start && (state == ST_IDLE);
    assign step   = (state == ST_RUN);

    sdr_operand_prep #(.W(W)) u_prep (
        .op       (sdr_op_e'(op_sel)),
        .size     (decode_size(size_imm)),
        .dividend (dividend),
        .divisor  (divisor),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .ctl      (ctl_now)
    );

    sdr_shift_core #(.W(W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .step  (step),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .quo   (quo),
        .rem   (rem)
    );

    sdr_result_fix #(.W(W)) u_fix (
        .quo    (quo),
        .rem    (rem),
        .orig   (orig_q),
        .ctl    (ctl_q),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            ctl_q  <= '0;
            orig_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state  <= ST_RUN;
                    cnt    <= '0;
                    ctl_q  <= ctl_now;
                    orig_q <= dividend;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(W - 1)) state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_FIN);
    assign wr_en = done && !ctl_q.zero_div;

    // Independent latency counter for the timing checks.
    logic [LW-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy) lat_cnt <= '0;
        else              lat_cnt <= lat_cnt + 1'b1;
    end

    assert_wr_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_latency_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && lat_cnt == LW'(W)));

    assert_busy_falls_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> (busy && $stable(orig_q)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!done && !wr_en));

endmodule

// File: tb/test_sized_divider.sv
module test_sized_divider;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [15:0] size_imm = '0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, wr_en;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        int          t0;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sized_divider i_sized_divider (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .size_imm(size_imm), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .wr_en(wr_en), .result(result)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void model(input logic [1:0] op, input logic [15:0] imm,
                                  input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] res, output logic wr);
        logic signed [31:0] sa, sb;
        logic sgn, remop;
        sgn   = (op == 2'd0) || (op == 2'd2);
        remop = (op == 2'd2) || (op == 2'd3);
        sb    = b;
        sa    = a;
        if (sgn && imm == 16'h0010) sa = {{16{a[15]}}, a[15:0]};
        if (sgn && imm == 16'h0018) sa = {{24{a[7]}}, a[7:0]};
        wr = 1'b1;
        if (b == 32'd0) begin
            res = a; wr = 1'b0;
        end else if (sgn) begin
            if (sb == -32'sd1) res = remop ? 32'd0 : (32'd0 - sa);
            else               res = remop ? (sa % sb) : (sa / sb);
        end else begin
            res = remop ? (a % b) : (a / b);
        end
    endfunction

    task automatic issue(input logic [1:0] op, input logic [15:0] imm,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        op_sel = op; size_imm = imm; dividend = a; divisor = b; start = 1'b1;
        model(op, imm, a, b, e.res, e.wr);
        e.t0 = cyc + 1;
        e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (expq.size() == 0) begin
                check(1'b0, "R10 unexpected done", {31'd0, done}, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(result == e.res, e.tag, result, e.res);
                check(wr_en == e.wr, {e.tag, " wr_en (R8)"}, {31'd0, wr_en}, {31'd0, e.wr});
                check(cyc - e.t0 == 32, "R9 latency", cyc - e.t0, 32);
                check(busy == 1'b1, "R9 busy at done", {31'd0, busy}, 32'd1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, wr_en} == 3'b000, "R11 in reset", {29'd0, busy, done, wr_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done, wr_en} == 3'b000, "R11 after reset", {29'd0, busy, done, wr_en}, 32'd0);

        // R1: each op code
        issue(2'd0, 16'h0000, 32'd100, 32'd7, "R1 sdiv");
        issue(2'd1, 16'h0000, 32'd100, 32'd7, "R1 udiv");
        issue(2'd2, 16'h0000, 32'd100, 32'd7, "R1 srem");
        issue(2'd3, 16'h0000, 32'd100, 32'd7, "R1 urem");
        // R6: sign combinations
        issue(2'd0, 16'h0000, -32'sd100, 32'd7,  "R6 neg/pos quo");
        issue(2'd2, 16'h0000, -32'sd100, 32'd7,  "R6 neg/pos rem");
        issue(2'd0, 16'h0000, 32'd100, -32'sd7,  "R6 pos/neg quo");
        issue(2'd2, 16'h0000, 32'd100, -32'sd7,  "R6 pos/neg rem");
        issue(2'd0, 16'h0000, -32'sd100, -32'sd7, "R6 neg/neg quo");
        issue(2'd2, 16'h0000, -32'sd100, -32'sd7, "R6 neg/neg rem");
        issue(2'd1, 16'h0000, -32'sd100, 32'd7,  "R1 udiv large");
        // R7
        issue(2'd0, 16'h0000, 32'h8000_0000, 32'hFFFF_FFFF, "R7 min/-1 quo");
        issue(2'd2, 16'h0000, 32'h8000_0000, 32'hFFFF_FFFF, "R7 min/-1 rem");
        // R3 / R4 / R5 / R2
        issue(2'd0, 16'h0010, 32'h1234_8005, 32'd3, "R3 half sdiv");
        issue(2'd2, 16'h0010, 32'h1234_8005, 32'd3, "R3 half srem");
        issue(2'd0, 16'h0018, 32'h0000_01F0, 32'd3, "R4 byte sdiv");
        issue(2'd2, 16'h0018, 32'h7777_7F85, 32'd10, "R4 byte srem");
        issue(2'd1, 16'h0010, 32'h1234_8005, 32'd3, "R5 half udiv");
        issue(2'd3, 16'h0018, 32'h0000_01F0, 32'd7, "R5 byte urem");
        issue(2'd0, 16'h0004, 32'h1234_8005, 32'd3, "R2 odd code word");
        issue(2'd0, 16'h0000, 32'h1234_8005, 32'd3, "R2 word code");
        issue(2'd1, 16'h0000, 32'hFFFF_FFFF, 32'd1, "R1 all-ones udiv");
        issue(2'd3, 16'h0000, 32'd5, 32'hFFFF_FFF0, "R1 big divisor urem");
        // R8
        issue(2'd0, 16'h0000, 32'hDEAD_BEEF, 32'd0, "R8 zero div sdiv");
        issue(2'd3, 16'h0018, 32'h0BAD_F00D, 32'd0, "R8 zero div urem");

        // R10: start while busy is ignored
        issue(2'd1, 16'h0000, 32'd1000, 32'd10, "R10 first op kept");
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R9 busy mid-op", {31'd0, busy}, 32'd1);
        op_sel = 2'd3; dividend = 32'd77; divisor = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);
        check(expq.size() == 0, "R10 queue drained", expq.size(), 32'd0);
        check(busy == 1'b0, "R9 idle at end", {31'd0, busy}, 32'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule